// File: doc/BRIEF.md
# Cache-Line Fill Bus Read Controller

This block turns one read request from the core into one read cycle on an external processor-style bus. For each request it decides whether the read should become a full cache-line fill or a single uncached transfer. A request is cacheable unless something rules it out: a locked access, a page-level cache-disable flag, or a memory-type range result of uncacheable or write-combining. For a cacheable request it asserts an active-low cache-request pin and expects a four-beat burst of 64-bit data that fills a 32-byte line starting at the line-aligned address. For any other request it runs one 8-byte transfer at the 8-byte-aligned address.

System logic has the final say on cacheability. It answers the first ready strobe of a cycle with an active-low cache-enable input. If cache-enable is high at that strobe, the cycle ends after that single beat. When a cycle ends, the block pulses a completion output for one cycle. With that pulse it presents the assembled line and two fill permissions, one for L1 and one for L2. Page-table-walk reads never get L1 permission. They still get L2 permission when the line was filled as cacheable. The block accepts only one request at a time.

Top module: `line_fill_ctrl`

## Requirements
- R1: A request with no lock, no cache-disable and memory type 0 (write-back) is cacheable. The block starts one bus cycle (bus_start high for one cycle, the cycle after acceptance) with bus_cache_n low and bus_addr equal to the request address with bits [4:0] cleared.
- R2: A request with req_pcd high starts its cycle with bus_cache_n high and runs a single transfer.
- R3: Memory type 1 (uncacheable) or 2 (write-combining) makes the request uncacheable. Memory types 0 and 3 (write-through) leave it cacheable.
- R4: A request with req_lock high is never cacheable. bus_cache_n stays high for its cycle and neither fill permission is given.
- R5: A cacheable cycle that is not downgraded completes after exactly four ready strobes (bus_rdy_n low while the data phase is active), with any number of wait states between them. Beat k lands in done_line[64k+63:64k], with beat 0 at the line-aligned address.
- R6: An uncacheable cycle completes on its first ready strobe. bus_addr is the request address with bits [2:0] cleared. The beat lands in done_line[63:0], the upper bits are zero, and both fill permissions are low.
- R7: If bus_ken_n is high at the first ready strobe of a cacheable cycle, the cycle ends after that beat. The data goes to done_line[63:0], the rest of the line is zero, and neither fill permission is given.
- R8: bus_ken_n is sampled only with the first ready strobe. A high value on beats 2 to 4 does not shorten the burst and does not clear the permissions.
- R9: A page-table-walk request never gets fill_l1. It gets fill_l2 when it is filled as a cacheable line, and neither permission when it is uncacheable.
- R10: done is high for exactly one cycle, one cycle after the last accepted ready strobe. req_ready is low from acceptance through the done cycle. Ready strobes while no cycle is in its data phase are ignored.
- R11: After reset, req_ready is 1, bus_start is 0, bus_cache_n is 1, done is 0 and both fill permissions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle; the request is taken this cycle |
| req_addr | input | ADDR_W | Byte address of the read |
| req_lock | input | 1 | Locked access |
| req_pcd | input | 1 | Page-level cache-disable |
| req_mtype | input | 2 | Memory-type range result: 0 write-back, 1 uncacheable, 2 write-combining, 3 write-through |
| req_walk | input | 1 | Read belongs to a page-table walk |
| bus_start | output | 1 | One-cycle bus cycle start strobe |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_cache_n | output | 1 | Active-low cacheable-cycle request |
| bus_rdy_n | input | 1 | Active-low data-ready strobe from system logic |
| bus_ken_n | input | 1 | Active-low cache-enable from system logic, sampled with the first ready |
| bus_data | input | DATA_W | Read data beat |
| done | output | 1 | One-cycle completion pulse |
| done_line | output | DATA_W*BEATS | Assembled line; valid while done is high |
| fill_l1 | output | 1 | Line may be written into L1; valid while done is high |
| fill_l2 | output | 1 | Line may be written into L2; valid while done is high |

## Verification
The assertions assume that system logic drives bus_rdy_n and bus_ken_n with known values in every cycle after reset. They also assume it never ends a burst early by itself: a strobe on the data phase is the only way beats are counted. The stimulus holds bus_rdy_n high outside the beats it means to deliver, including the done cycle. It drives bus_ken_n only together with ready strobes, and it raises req_valid only while req_ready is high, so no request is dropped without being seen.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    MT_WB = 2'd0,
    MT_UC = 2'd1,
    MT_WC = 2'd2,
    MT_WT = 2'd3
  } mem_type_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } bus_state_e;

  // Write-combining counts as uncacheable.
  function automatic logic range_allows_cache(mem_type_e mt);
    return !((mt == MT_UC) || (mt == MT_WC));
  endfunction

  function automatic logic core_wants_cache(logic lock, logic pcd, mem_type_e mt);
    return !lock && !pcd && range_allows_cache(mt);
  endfunction

endpackage

// File: rtl/lfc_policy.sv
module lfc_policy #(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 5,
  parameter int BEAT_OFF_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              pcd,
  input  logic [1:0]        mtype,
  input  logic              walk,
  output logic              want_cache,
  output logic              l1_ok,
  output logic              l2_ok,
  output logic [ADDR_W-1:0] cyc_addr
);
  import lfc_pkg::*;

  function automatic logic [ADDR_W-1:0] align_line(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] align_beat(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BEAT_OFF_W], {BEAT_OFF_W{1'b0}}};
  endfunction

  always_comb begin
    want_cache = core_wants_cache(lock, pcd, mem_type_e'(mtype));
    l2_ok      = want_cache;
    l1_ok      = want_cache && !walk;
    cyc_addr   = want_cache ? align_line(addr) : align_beat(addr);
  end

endmodule

// File: rtl/lfc_line_buf.sv
module lfc_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W*BEATS-1:0] line
);

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (clear)                              slot_q <= '0;
      else if (we && (idx == IDX_W'(g)))           slot_q <= wdata;
    end
    assign line[g*DATA_W +: DATA_W] = slot_q;
  end

endmodule

// File: rtl/lfc_bus_seq.sv
module lfc_bus_seq #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              want_cache,
  input  logic              l1_ok,
  input  logic              l2_ok,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              rdy_n,
  input  logic              ken_n,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cache_n,
  output logic              buf_clear,
  output logic              beat_we,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              in_data,
  output logic              done,
  output logic              fill_l1,
  output logic              fill_l2
);
  import lfc_pkg::*;

  bus_state_e        state;
  logic              cache_q, l1_q, l2_q, burst_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  // named events
  logic beat_take, first_rdy, burst_on, last_beat, in_cycle, downgrade;

  always_comb begin
    in_data   = (state == ST_DATA);
    in_cycle  = (state == ST_ADDR) || (state == ST_DATA);
    beat_take = in_data && !rdy_n;
    first_rdy = beat_take && (idx_q == '0);
    burst_on  = first_rdy ? (cache_q && !ken_n) : burst_q;
    downgrade = first_rdy && cache_q && ken_n;
    last_beat = beat_take && (!burst_on || (idx_q == IDX_W'(BEATS-1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cache_q <= 1'b0;
      l1_q    <= 1'b0;
      l2_q    <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cache_q <= want_cache;
          l1_q    <= l1_ok;
          l2_q    <= l2_ok;
          addr_q  <= cyc_addr;
          idx_q   <= '0;
          burst_q <= 1'b0;
          state   <= ST_ADDR;
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: if (beat_take) begin
          idx_q   <= idx_q + 1'b1;
          burst_q <= burst_on;
          if (!burst_on) begin
            l1_q <= 1'b0;
            l2_q <= 1'b0;
          end
          if (last_beat) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign buf_clear   = req_valid && req_ready;
  assign bus_start   = (state == ST_ADDR);
  assign bus_addr    = addr_q;
  assign bus_cache_n = in_cycle ? !cache_q : 1'b1;
  assign beat_we     = beat_take;
  assign beat_idx    = idx_q;
  assign done        = (state == ST_DONE);
  assign fill_l1     = done && l1_q;
  assign fill_l2     = done && l2_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start && in_data); // R1
  AST_CACHE_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_cycle)) |-> $stable(bus_cache_n)); // R1
  AST_KEN_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    downgrade |=> done && !fill_l1 && !fill_l2); // R7
  AST_L1_NEEDS_L2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_l1 |-> fill_l2); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle || done) |-> !req_ready); // R10

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int LINE_W     = DATA_W * BEATS,
  localparam int BEAT_OFF_W = $clog2(DATA_W / 8),
  localparam int LINE_OFF_W = $clog2(DATA_W / 8 * BEATS),
  localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CNT_W      = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_lock,
  input  logic              req_pcd,
  input  logic [1:0]        req_mtype,
  input  logic              req_walk,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cache_n,
  input  logic              bus_rdy_n,
  input  logic              bus_ken_n,
  input  logic [DATA_W-1:0] bus_data,
  output logic              done,
  output logic [LINE_W-1:0] done_line,
  output logic              fill_l1,
  output logic              fill_l2
);

  logic              want_cache, l1_ok, l2_ok;
  logic [ADDR_W-1:0] cyc_addr;
  logic              buf_clear, beat_we, in_data;
  logic [IDX_W-1:0]  beat_idx;

  lfc_policy #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .BEAT_OFF_W(BEAT_OFF_W)
  ) u_policy (
    .addr(req_addr), .lock(req_lock), .pcd(req_pcd), .mtype(req_mtype),
    .walk(req_walk), .want_cache(want_cache), .l1_ok(l1_ok), .l2_ok(l2_ok),
    .cyc_addr(cyc_addr)
  );

  lfc_bus_seq #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .want_cache(want_cache), .l1_ok(l1_ok), .l2_ok(l2_ok), .cyc_addr(cyc_addr),
    .rdy_n(bus_rdy_n), .ken_n(bus_ken_n), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_cache_n(bus_cache_n), .buf_clear(buf_clear),
    .beat_we(beat_we), .beat_idx(beat_idx), .in_data(in_data), .done(done),
    .fill_l1(fill_l1), .fill_l2(fill_l2)
  );

  lfc_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .we(beat_we),
    .idx(beat_idx), .wdata(bus_data), .line(done_line)
  );

  // Independent count of ready strobes seen in the data phase of a cycle.
  logic [CNT_W-1:0] obs_beats;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     obs_beats <= '0;
    else if (bus_start)             obs_beats <= '0;
    else if (in_data && !bus_rdy_n) obs_beats <= obs_beats + 1'b1;
  end

  AST_FILL_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fill_l2) |-> (obs_beats == CNT_W'(BEATS))); // R5
  AST_SHORT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (obs_beats == CNT_W'(1))) |-> (!fill_l1 && !fill_l2)); // R6
  AST_LOCK_NOT_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lock) |=> bus_cache_n); // R4

endmodule

// File: tb/line_fill_ctrl_test.sv
`timescale 1ns/1ps
module line_fill_ctrl_test;
  localparam int AW = 32, DW = 64, NB = 4, LW = DW * NB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_lock = 1'b0, req_pcd = 1'b0, req_walk = 1'b0;
  logic [1:0] req_mtype = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic bus_rdy_n = 1'b1, bus_ken_n = 1'b1;
  logic [DW-1:0] bus_data = '0;
  logic req_ready, bus_start, bus_cache_n, done, fill_l1, fill_l2;
  logic [AW-1:0] bus_addr;
  logic [LW-1:0] done_line;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  line_fill_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_lock(req_lock), .req_pcd(req_pcd),
    .req_mtype(req_mtype), .req_walk(req_walk), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_cache_n(bus_cache_n), .bus_rdy_n(bus_rdy_n),
    .bus_ken_n(bus_ken_n), .bus_data(bus_data), .done(done),
    .done_line(done_line), .fill_l1(fill_l1), .fill_l2(fill_l2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat_val(input int seed, input int b);
    return {32'(seed) ^ 32'h5A5A_0000, 32'hC0DE_0000 + 32'(b)};
  endfunction

  // One read scenario. creq: bus_cache_n expected low. nbeats: strobes to end.
  task automatic do_read(input string req, input logic [AW-1:0] a,
                         input logic lk, input logic pcd, input logic [1:0] mt,
                         input logic wk, input logic ken_first, input logic ken_later,
                         input bit waits, input bit creq, input int nbeats,
                         input bit e_l1, input bit e_l2, input int seed);
    logic [AW-1:0] e_addr;
    logic [LW-1:0] e_line;
    e_addr = creq ? {a[AW-1:5], 5'b0} : {a[AW-1:3], 3'b0};
    e_line = '0;
    @(negedge clk);
    chk(req_ready == 1'b1, req, "ready before request", LW'(req_ready), LW'(1));
    req_valid = 1'b1; req_addr = a; req_lock = lk; req_pcd = pcd;
    req_mtype = mt; req_walk = wk;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_start == 1'b1, req, "bus_start", LW'(bus_start), LW'(1));
    chk(bus_cache_n == !creq, req, "bus_cache_n", LW'(bus_cache_n), LW'(!creq));
    chk(bus_addr == e_addr, req, "bus_addr", LW'(bus_addr), LW'(e_addr));
    chk(req_ready == 1'b0, "R10", "ready while busy", LW'(req_ready), LW'(0));
    @(negedge clk);
    for (int b = 0; b < nbeats; b++) begin
      if (waits) begin
        bus_rdy_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, req, "done during wait", LW'(done), LW'(0));
      end
      bus_rdy_n = 1'b0;
      bus_data  = beat_val(seed, b);
      bus_ken_n = (b == 0) ? ken_first : ken_later;
      e_line[b*DW +: DW] = beat_val(seed, b);
      @(negedge clk);
      if (b < nbeats - 1)
        chk(done == 1'b0, req, "done before last strobe", LW'(done), LW'(0));
    end
    bus_rdy_n = 1'b1; bus_ken_n = 1'b1;
    chk(done == 1'b1, req, "done after last strobe", LW'(done), LW'(1));
    chk(done_line == e_line, req, "line data", done_line, e_line);
    chk(fill_l1 == e_l1, req, "fill_l1", LW'(fill_l1), LW'(e_l1));
    chk(fill_l2 == e_l2, req, "fill_l2", LW'(fill_l2), LW'(e_l2));
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R10", "one-cycle done then idle",
        LW'({done, req_ready}), LW'(2'b01));
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1, "R11", "req_ready", LW'(req_ready), LW'(1));
    chk(bus_start == 1'b0, "R11", "bus_start", LW'(bus_start), LW'(0));
    chk(bus_cache_n == 1'b1, "R11", "bus_cache_n", LW'(bus_cache_n), LW'(1));
    chk({done, fill_l1, fill_l2} == 3'b000, "R11", "done/fills",
        LW'({done, fill_l1, fill_l2}), LW'(0));
  endtask

  task automatic test_idle_strobes();
    @(negedge clk);
    bus_rdy_n = 1'b0; bus_ken_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b0 && bus_start == 1'b0, "R10", "idle strobe ignored",
          LW'({done, bus_start}), LW'(0));
    end
    bus_rdy_n = 1'b1; bus_ken_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5: default cacheable burst
    do_read("R1", 32'h1234_5678, 0, 0, 2'd0, 0, 0, 0, 0, 1, 4, 1, 1, 1);
    // R3 R5: write-through cacheable, wait states between strobes
    do_read("R5", 32'h0000_0FE8, 0, 0, 2'd3, 0, 0, 0, 1, 1, 4, 1, 1, 2);
    // R2 R6: page cache-disable
    do_read("R2", 32'h8000_107D, 0, 1, 2'd0, 0, 0, 0, 0, 0, 1, 0, 0, 3);
    // R3: uncacheable and write-combining ranges
    do_read("R3", 32'h4000_0013, 0, 0, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0, 4);
    do_read("R3", 32'h4000_0026, 0, 0, 2'd2, 0, 0, 0, 1, 0, 1, 0, 0, 5);
    // R4: locked
    do_read("R4", 32'h0BAD_F00F, 1, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 0, 6);
    // R7: system logic downgrades on the first strobe
    do_read("R7", 32'h2222_3339, 0, 0, 2'd0, 0, 1, 0, 0, 1, 1, 0, 0, 7);
    // R8: ken high on later beats is ignored
    do_read("R8", 32'h7777_0040, 0, 0, 2'd0, 0, 0, 1, 1, 1, 4, 1, 1, 8);
    // R9: page-table walk, cacheable and uncacheable
    do_read("R9", 32'h0010_0ABC, 0, 0, 2'd0, 1, 0, 0, 0, 1, 4, 0, 1, 9);
    do_read("R9", 32'h0010_0AC4, 0, 1, 2'd0, 1, 0, 0, 0, 0, 1, 0, 0, 10);
    // R6: uncacheable single transfer with a wait state
    do_read("R6", 32'hFFFF_FFFF, 0, 0, 2'd1, 0, 0, 0, 1, 0, 1, 0, 0, 11);
    // R10: strobes while idle
    test_idle_strobes();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule